// File: doc/BRIEF.md
# Sensor Error Flag Supervisor

This block supervises a closed-loop magnetic current sensor and condenses its health into two active-low, open-drain style flags: a system error flag and an over-range flag. Each flag is modelled as a pull-enable bit. A value of 1 means the pin is pulled low. The two flags may be wired together by the board. Around the supervisor sit analog comparators, which are not part of this block. They report the fluxgate probe polarity, supply-good, a low-supply (brownout) level, a compensation driver near its rail, a low compensation-coil current and a saturated shunt amplifier.

After supply-good, and with no demagnetization cycle running, the supervisor waits for a start delay. It then enables the probe and watches its half-periods. The compensation driver starts, and the error flag is released, only after four consecutive full probe cycles whose halves all lie strictly inside a window. Each fault source then has its own duration qualifier:
- a missing probe edge times out and sends the block back to qualification;
- a long brownout requests a full reset, while a short one is ignored;
- a wire-break condition (driver near the rail with low coil current) sets only the error flag, and only when its diagnostic is enabled;
- amplifier saturation drives the over-range flag after a short hold-off.

States: `S_OFF` (unpowered or reset), `S_WAIT` (start delay), `S_QUAL` (probe qualification), `S_RUN` (normal operation). Transitions:
- `S_OFF`→`S_WAIT` when supply-good is high and no long brownout is present.
- `S_WAIT`→`S_QUAL` after the start delay has run with demag idle.
- `S_QUAL`→`S_RUN` when four good cycles have been seen.
- `S_RUN`→`S_QUAL` on a probe timeout.
- Any state →`S_OFF` when supply-good is lost or a long brownout occurs.

Top module: `sensor_flag_sup`

## Requirements
- R1: During reset, and while in `S_OFF`, `err_pull`=1, `probe_en`=0 and `drv_en`=0.
- R2: With `demag_busy`=0, `probe_en` rises exactly START_DLY clock edges after the state is `S_WAIT`. While `demag_busy`=1, the start count is held at zero.
- R3: The probe length of a half-period is the number of clock edges between two polarity changes. A half is good when HALF_MIN < length < HALF_MAX. The first edge after entering `S_QUAL` is only a reference. After 2*GOOD_CYCLES (8) consecutive good halves, `drv_en` becomes 1 and `err_pull` is released. A bad half restarts the count.
- R4: If no probe edge occurs for HALF_MAX clock edges in `S_RUN`, then `drv_en` drops and `err_pull`=1. Readiness again needs eight consecutive good halves.
- R5: A brownout held for fewer than BROWN_LIM edges has no effect. When it is held for BROWN_LIM edges, `por_req`=1 and the block returns to `S_OFF`, then restarts the power-up sequence.
- R6: When `wb_diag_en`=1 and `rail_near`&`coil_low` is held for WIRE_LIM edges, `err_pull`=1 while `drv_en` and `probe_en` stay 1. When `wb_diag_en`=0 the condition is ignored.
- R7: `ovr_pull`=1 once `amp_sat` has been held for OVR_LIM edges. It returns to 0 in the same cycle that `amp_sat` falls.
- R8: `demag_busy`=1 forces `err_pull`=1 at once. The flag clears by itself when demag ends in `S_RUN`.
- R9: Every duration qualifier restarts from zero when its condition drops before expiry.
- R10: Loss of `supply_ok` sends the block to `S_OFF` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe_pol | input | 1 | Probe comparator polarity |
| supply_ok | input | 1 | Supply above power-on threshold |
| brownout | input | 1 | Supply below brownout level |
| rail_near | input | 1 | A compensation driver output is near ground |
| coil_low | input | 1 | Compensation coil current below threshold |
| wb_diag_en | input | 1 | Wire-break diagnostic enable |
| demag_busy | input | 1 | Demagnetization cycle in progress |
| amp_sat | input | 1 | Shunt amplifier outside its linear range |
| err_pull | output | 1 | Error flag pull-low enable |
| ovr_pull | output | 1 | Over-range flag pull-low enable |
| probe_en | output | 1 | Probe excitation enable |
| drv_en | output | 1 | Compensation driver enable |
| por_req | output | 1 | Full reset request from a long brownout |

## Verification
The assertions assume that the comparator inputs are synchronous to the clock and change only between edges. They also assume that a start of demag or a loss of supply is a level held for at least one edge. The bench keeps within these assumptions by driving every input at the falling edge. Random pulse lengths are drawn around each qualifier limit so that both sides of every boundary occur. The probe toggles from a single bench process with a half-period kept inside the good window, except where a timeout or a bad half is the intent.

// File: rtl/sup_pkg.sv
package sup_pkg;
    typedef enum logic [1:0] {
        S_OFF  = 2'd0,
        S_WAIT = 2'd1,
        S_QUAL = 2'd2,
        S_RUN  = 2'd3
    } sup_state_t;
endpackage

// File: rtl/sup_dur_qual.sv
// Duration qualifier: hit goes high after the input has been true for LIM edges.
module sup_dur_qual #(
    parameter int LIM = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic hit
);
    localparam int CW = $clog2(LIM + 1);
    localparam logic [CW-1:0] LIM_V = CW'(LIM);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!cond) begin
            cnt <= '0;
        end else if (cnt != LIM_V) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit = cond && (cnt == LIM_V);
endmodule

// File: rtl/sup_probe_mon.sv
// Measures probe half-periods, counts consecutive good halves, flags timeout.
module sup_probe_mon #(
    parameter int HALF_MIN    = 28,
    parameter int HALF_MAX    = 3200,
    parameter int GOOD_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic probe_pol,
    output logic ready,
    output logic timeout
);
    localparam int HW = $clog2(HALF_MAX + 1);
    localparam int TARGET = 2 * GOOD_CYCLES;
    localparam int GW = $clog2(TARGET + 1);
    localparam logic [HW-1:0] HMAX_V = HW'(HALF_MAX);
    localparam logic [HW:0]   LMIN_V = (HW+1)'(HALF_MIN);
    localparam logic [HW:0]   LMAX_V = (HW+1)'(HALF_MAX);
    localparam logic [GW-1:0] TGT_V  = GW'(TARGET);

    logic          pol_q;
    logic          edge_seen;
    logic [HW-1:0] half_cnt;
    logic [HW:0]   half_len;
    logic          half_good;
    logic          seen;
    logic [GW-1:0] halves;

    assign edge_seen = probe_pol ^ pol_q;
    assign half_len  = {1'b0, half_cnt} + 1'b1;
    assign half_good = (half_len > LMIN_V) && (half_len < LMAX_V);
    assign timeout   = !edge_seen && (half_cnt >= HMAX_V);
    assign ready     = (halves == TGT_V);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q    <= 1'b0;
            half_cnt <= '0;
        end else begin
            pol_q <= probe_pol;
            if (edge_seen) begin
                half_cnt <= '0;
            end else if (half_cnt != HMAX_V) begin
                half_cnt <= half_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen   <= 1'b0;
            halves <= '0;
        end else if (clr) begin
            seen   <= 1'b0;
            halves <= '0;
        end else if (edge_seen) begin
            if (!seen) begin
                seen   <= 1'b1;
                halves <= '0;
            end else if (!half_good) begin
                halves <= '0;
            end else if (halves != TGT_V) begin
                halves <= halves + 1'b1;
            end
        end else if (timeout) begin
            seen   <= 1'b0;
            halves <= '0;
        end
    end
endmodule

// File: rtl/sensor_flag_sup.sv
module sensor_flag_sup
    import sup_pkg::*;
#(
    parameter int HALF_MIN    = 28,
    parameter int HALF_MAX    = 3200,
    parameter int GOOD_CYCLES = 4,
    parameter int START_DLY   = 3200,
    parameter int BROWN_LIM   = 10000,
    parameter int WIRE_LIM    = 10000,
    parameter int OVR_LIM     = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic probe_pol,
    input  logic supply_ok,
    input  logic brownout,
    input  logic rail_near,
    input  logic coil_low,
    input  logic wb_diag_en,
    input  logic demag_busy,
    input  logic amp_sat,
    output logic err_pull,
    output logic ovr_pull,
    output logic probe_en,
    output logic drv_en,
    output logic por_req
);
    localparam int SW = $clog2(START_DLY + 1);
    localparam logic [SW-1:0] START_LAST = SW'(START_DLY - 1);

    sup_state_t state, state_nx;
    logic [SW-1:0] st_cnt;
    logic bo_long, wire_fault, probe_ready, probe_to, mon_clr, power_bad;

    sup_dur_qual #(.LIM(BROWN_LIM)) u_bo_q (
        .clk(clk), .rst_n(rst_n), .cond(brownout), .hit(bo_long));

    sup_dur_qual #(.LIM(WIRE_LIM)) u_wire_q (
        .clk(clk), .rst_n(rst_n),
        .cond(wb_diag_en && rail_near && coil_low), .hit(wire_fault));

    sup_dur_qual #(.LIM(OVR_LIM)) u_ovr_q (
        .clk(clk), .rst_n(rst_n), .cond(amp_sat), .hit(ovr_pull));

    sup_probe_mon #(
        .HALF_MIN(HALF_MIN), .HALF_MAX(HALF_MAX), .GOOD_CYCLES(GOOD_CYCLES)
    ) u_mon (
        .clk(clk), .rst_n(rst_n), .clr(mon_clr), .probe_pol(probe_pol),
        .ready(probe_ready), .timeout(probe_to));

    assign power_bad = !supply_ok || bo_long;
    assign mon_clr   = (state != S_QUAL);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_OFF;
        end else begin
            state <= state_nx;
        end
    end

    // start delay counter, active only in S_WAIT with demag idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_cnt <= '0;
        end else if (state != S_WAIT || demag_busy) begin
            st_cnt <= '0;
        end else if (st_cnt != START_LAST) begin
            st_cnt <= st_cnt + 1'b1;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_OFF:  if (!power_bad) state_nx = S_WAIT;
            S_WAIT: begin
                if (power_bad)
                    state_nx = S_OFF;
                else if (!demag_busy && st_cnt == START_LAST)
                    state_nx = S_QUAL;
            end
            S_QUAL: begin
                if (power_bad)        state_nx = S_OFF;
                else if (probe_ready) state_nx = S_RUN;
            end
            S_RUN: begin
                if (power_bad)     state_nx = S_OFF;
                else if (probe_to) state_nx = S_QUAL;
            end
            default: state_nx = S_OFF;
        endcase
    end

    // outputs
    always_comb begin
        probe_en = 1'b0;
        drv_en   = 1'b0;
        unique case (state)
            S_OFF, S_WAIT: ;
            S_QUAL: probe_en = 1'b1;
            S_RUN: begin
                probe_en = 1'b1;
                drv_en   = 1'b1;
            end
            default: ;
        endcase
        err_pull = (state != S_RUN) || demag_busy || wire_fault;
        por_req  = bo_long;
    end
endmodule

// File: rtl/sup_chk.sv
module sup_chk (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic demag_busy,
    input logic amp_sat,
    input logic err_pull,
    input logic ovr_pull,
    input logic probe_en,
    input logic drv_en,
    input logic por_req
);
    // R7
    ovr_needs_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_pull |-> amp_sat);
    // R6
    drv_implies_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> probe_en);
    // R10
    supply_loss_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!probe_en && err_pull));
    // R8
    demag_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        demag_busy |-> err_pull);
    // R5
    por_stops_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        por_req |=> !probe_en);
    // R3
    drv_start_from_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_en) |-> $past(probe_en));
endmodule

bind sensor_flag_sup sup_chk u_chk (.*);

// File: tb/sensor_flag_sup_bench.sv
`timescale 1ns/1ps
module sensor_flag_sup_bench;
    localparam int HMIN = 4, HMAX = 40, GOODC = 4, STD = 30;
    localparam int BLIM = 60, WLIM = 50, OLIM = 8, PH = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic probe_pol = 1'b0, supply_ok = 1'b0, brownout = 1'b0;
    logic rail_near = 1'b0, coil_low = 1'b0, wb_diag_en = 1'b1;
    logic demag_busy = 1'b0, amp_sat = 1'b0;
    logic err_pull, ovr_pull, probe_en, drv_en, por_req;
    logic auto_on = 1'b0;
    int   n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    sensor_flag_sup #(
        .HALF_MIN(HMIN), .HALF_MAX(HMAX), .GOOD_CYCLES(GOODC), .START_DLY(STD),
        .BROWN_LIM(BLIM), .WIRE_LIM(WLIM), .OVR_LIM(OLIM)
    ) u_sensor_flag_sup (.*);

    // background probe oscillation with a good half-period
    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            if (auto_on) begin
                c++;
                if (c >= PH) begin probe_pol = ~probe_pol; c = 0; end
            end else c = 0;
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic edge_after(input int h);
        probe_pol = ~probe_pol;
        cyc(h);
    endtask

    function automatic logic exp_hit(input int len, input int lim);
        return len >= lim;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        cyc(3);
        // R1 reset state
        chk(err_pull, 1'b1, "R1 err in reset");
        chk(probe_en, 1'b0, "R1 probe in reset");
        chk(drv_en, 1'b0, "R1 drv in reset");
        rst_n = 1'b1;
        cyc(2);
        chk(err_pull, 1'b1, "R1 err with supply low");
        // R8/R2 demag holds the start
        demag_busy = 1'b1;
        supply_ok = 1'b1;
        cyc(100);
        chk(probe_en, 1'b0, "R2 start held by demag");
        chk(err_pull, 1'b1, "R8 err during demag");
        demag_busy = 1'b0;
        cyc(STD - 1);
        chk(probe_en, 1'b0, "R2 one edge before start");
        cyc(1);
        chk(probe_en, 1'b1, "R2 start after delay");
        // R3 qualification with a bad half in the middle
        edge_after(PH);          // reference
        edge_after(PH);
        edge_after(2);           // bad short half follows
        edge_after(PH);          // this edge closes the short half
        for (int i = 0; i < 6; i++) edge_after(PH);
        edge_after(3);           // seventh good half measured at this edge
        chk(drv_en, 1'b0, "R3 seven good halves not ready");
        chk(err_pull, 1'b1, "R3 err before ready");
        // the next edge closes a 3-cycle half: bad, restarts
        edge_after(PH);
        for (int i = 0; i < 7; i++) edge_after(PH);
        chk(drv_en, 1'b0, "R3 restart after bad half");
        probe_pol = ~probe_pol;  // eighth good half
        auto_on = 1'b1;
        cyc(3);
        chk(drv_en, 1'b1, "R3 ready after eight good halves");
        chk(err_pull, 1'b0, "R3 err released");
        // R7/R9 over-range random pulses
        for (int i = 0; i < 20; i++) begin
            int len = $urandom_range(1, 15);
            amp_sat = 1'b1;
            cyc(len);
            chk(ovr_pull, exp_hit(len, OLIM), "R7 R9 ovr after pulse");
            amp_sat = 1'b0;
            #1;
            chk(ovr_pull, 1'b0, "R7 ovr release");
            cyc(2);
        end
        // R6/R9 wire-break random pulses
        for (int i = 0; i < 8; i++) begin
            int len = $urandom_range(WLIM - 15, WLIM + 15);
            rail_near = 1'b1; coil_low = 1'b1;
            cyc(len);
            chk(err_pull, exp_hit(len, WLIM), "R6 R9 wire err");
            chk(drv_en, 1'b1, "R6 driver kept");
            rail_near = 1'b0;
            cyc(2);
            chk(err_pull, 1'b0, "R6 wire err cleared");
            coil_low = 1'b0;
        end
        wb_diag_en = 1'b0;
        rail_near = 1'b1; coil_low = 1'b1;
        cyc(WLIM * 3);
        chk(err_pull, 1'b0, "R6 diagnostic disabled ignored");
        rail_near = 1'b0; coil_low = 1'b0; wb_diag_en = 1'b1;
        // R8 demag in run
        demag_busy = 1'b1;
        #1;
        chk(err_pull, 1'b1, "R8 demag err immediate");
        cyc(5);
        demag_busy = 1'b0;
        #1;
        chk(err_pull, 1'b0, "R8 demag err clears");
        // R5/R9 short brownouts
        for (int i = 0; i < 6; i++) begin
            int len = $urandom_range(BLIM - 20, BLIM - 1);
            brownout = 1'b1;
            cyc(len);
            chk(por_req, 1'b0, "R5 R9 short brownout ignored");
            brownout = 1'b0;
            cyc(2);
            chk(drv_en, 1'b1, "R5 run kept after short brownout");
        end
        brownout = 1'b1;
        cyc(BLIM);
        chk(por_req, 1'b1, "R5 long brownout reset request");
        cyc(1);
        chk(probe_en, 1'b0, "R5 block reset");
        brownout = 1'b0;
        cyc(STD + 200);
        chk(drv_en, 1'b1, "R5 restarted after brownout");
        // R4 probe timeout
        auto_on = 1'b0;
        cyc(HMAX + 5);
        chk(err_pull, 1'b1, "R4 timeout err");
        chk(drv_en, 1'b0, "R4 timeout driver off");
        auto_on = 1'b1;
        cyc(5 * PH);
        chk(drv_en, 1'b0, "R4 requalify needs four cycles");
        cyc(100);
        chk(drv_en, 1'b1, "R4 requalified");
        // R10 supply loss
        supply_ok = 1'b0;
        cyc(1);
        chk(probe_en, 1'b0, "R10 supply loss off");
        chk(err_pull, 1'b1, "R10 err on supply loss");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule